// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master with Selectable Parity

This block is the master-side front end for a 32-bit bus that carries the address and the data on the same wires. A local client raises a request carrying an address, active-low byte enables, a direction and a beat count. The request is acknowledged in the same clock. The block then puts the address on the shared bus for one clock and moves one data word on each following clock. Write words are taken from the client one per clock. Read words come back one clock later with a valid strobe.

The parity bus has four lines. Three run-time controls set its behaviour: parity on or off, odd or even, and per byte or per word. In per-byte mode each line covers one byte of the bus. In per-word mode only the top line is used, and it covers all 32 bits. The parity lines drive on the address clock and on write data clocks, and they are sampled on read data clocks. A mismatch on any active lane gives a one-clock error pulse and sets a sticky flag. The client clears the flag by pulsing a clear input.

Three-state pins are modelled as separate output enables for the bus, the parity lanes and the byte enables. An active-low output-enable input forces the bus and the parity lines off while the cycle still runs.

The sequencer has three states:
- `ST_IDLE`: the bus is released.
- `ST_ADDR`: the address clock.
- `ST_DATA`: one state per data beat.

It has four transitions:
- accept: `ST_IDLE` to `ST_ADDR`, on a request with no slave access.
- address done: `ST_ADDR` to `ST_DATA`, always.
- next beat: `ST_DATA` to `ST_DATA`, while beats remain.
- last beat: `ST_DATA` to `ST_IDLE`.

Top module: `mux_bus_master`

## Requirements
- R1: After reset, `req_ack`, `ad_oe`, `be_oe`, `par_oe`, `wr_take`, `rd_valid`, `par_err_pulse` and `par_err_sticky` are all 0, and `be_n_o` is 4'hF.
- R2: When `req` is high in idle and `slave_acc` is low, `req_ack` is 1 in that same clock. On the next clock `ad_o` carries the captured address. The following `req_len`+1 clocks are data clocks. `be_oe` is 1 and `be_n_o` holds the captured enables (bit 3 for AD[31:24], bit 0 for AD[7:0]) from the address clock through the last data clock.
- R3: In idle, `ad_oe`, `be_oe` and `par_oe` are 0. While `slave_acc` is 1, no request is acknowledged.
- R4: On each write data clock, `wr_take` is 1, `ad_o` equals `wr_data` and `ad_oe` is 1.
- R5: On a read data clock, `ad_oe` is 0. One clock later `rd_valid` is 1 and `rd_data` holds the sampled `ad_i`.
- R6: Even parity makes the covered bits plus the parity bit hold an even number of ones. Odd parity makes that count odd. The parity type is set by `par_odd`: 1 means odd.
- R7: In byte mode (`par_byte`=1), lane k covers AD[8k+7:8k] and all four lanes are active. In word mode only lane 3 is active and it covers AD[31:0]; lanes 2 to 0 are never driven.
- R8: With parity enabled, the active lanes have `par_oe` set on the address clock and on write data clocks, and `par_o` carries the parity of `ad_o`. On read data clocks `par_oe` is 0.
- R9: While `oe_n` is 1, `ad_oe` and `par_oe` are 0. The sequence, `wr_take` and the byte enables proceed unchanged.
- R10: With parity enabled, a mismatch between `par_i` and the expected parity of `ad_i` on any active lane during a read data clock gives a one-clock `par_err_pulse` in the same clock as that word's `rd_valid`.
- R11: `par_err_sticky` sets with each error pulse. It clears in the clock after `err_clr` is 1. If a new error is detected in the same clock as the clear, the flag stays set.
- R12: With `par_en`=0, `par_oe` stays 0 and read parity never raises an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Transfer request |
| req_ack | output | 1 | Request accepted this clock |
| req_addr | input | 32 | Transfer address |
| req_be_n | input | 4 | Active-low byte enables |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | 4 | Data beats minus one |
| wr_data | input | 32 | Write word for the current data clock |
| wr_take | output | 1 | Write word consumed this clock |
| rd_data | output | 32 | Read word |
| rd_valid | output | 1 | Read word valid |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| par_byte | input | 1 | 1 = per-byte lanes, 0 = single word lane |
| err_clr | input | 1 | Clear sticky parity error |
| par_err_pulse | output | 1 | One-clock read parity error |
| par_err_sticky | output | 1 | Sticky parity error flag |
| slave_acc | input | 1 | Block is being accessed as a slave |
| oe_n | input | 1 | Active-low output-enable override |
| ad_o | output | 32 | Bus output value |
| ad_i | input | 32 | Bus input value |
| ad_oe | output | 1 | Bus output enable |
| par_o | output | 4 | Parity output lanes |
| par_i | input | 4 | Parity input lanes |
| par_oe | output | 4 | Per-lane parity output enable |
| be_n_o | output | 4 | Byte enable outputs |
| be_oe | output | 1 | Byte enable output enable |

## Verification
Two functions can fall in the same clock: detecting a new read parity error, and the client clearing the sticky flag. A directed read is run with corrupted parity on its first beat while `err_clr` is held during that beat. The flag must remain set afterward. A plain clear in idle must drop it. Random transactions with random parity modes and injected lane corruption are compared against a bench parity model built from bit counts.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } mbm_state_e;
endpackage

// File: rtl/mbm_parity.sv
module mbm_parity #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              odd,
    input  logic              byte_mode,
    output logic [LANES-1:0]  par
);
    logic word_x;
    assign word_x = ^data;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic lane_x;
        assign lane_x = ^data[8*k +: 8];
        if (k == LANES - 1) begin : g_top
            assign par[k] = byte_mode ? (lane_x ^ odd) : (word_x ^ odd);
        end else begin : g_low
            assign par[k] = byte_mode ? (lane_x ^ odd) : 1'b0;
        end
    end
endmodule

// File: rtl/mbm_seq.sv
module mbm_seq
    import mbm_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             slave_acc,
    input  logic [LEN_W-1:0] req_len,
    output logic             req_ack,
    output logic             in_addr,
    output logic             in_data,
    output logic             in_idle
);
    mbm_state_e       state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req && !slave_acc) begin
                    state_d = ST_ADDR;
                    cnt_d   = req_len;
                end
            end
            ST_ADDR: state_d = ST_DATA;
            ST_DATA: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        in_idle = (state_q == ST_IDLE);
        in_addr = (state_q == ST_ADDR);
        in_data = (state_q == ST_DATA);
        req_ack = in_idle && req && !slave_acc;
    end

    AST_ADDR_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR) |=> (state_q == ST_DATA)); // R2
    AST_ACK_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> (state_q == ST_ADDR)); // R2
endmodule

// File: rtl/mbm_perr.sv
module mbm_perr #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_en,
    input  logic [LANES-1:0] lanes,
    input  logic [LANES-1:0] par_seen,
    input  logic [LANES-1:0] par_want,
    input  logic             err_clr,
    output logic             err_pulse,
    output logic             err_sticky
);
    logic hit;
    assign hit = chk_en && (|((par_seen ^ par_want) & lanes));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_pulse  <= 1'b0;
            err_sticky <= 1'b0;
        end else begin
            err_pulse <= hit;
            if (hit)          err_sticky <= 1'b1;
            else if (err_clr) err_sticky <= 1'b0;
        end
    end

    AST_STICKY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> err_sticky); // R11
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !chk_en) |=> !err_sticky); // R11
endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 4,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    output logic              req_ack,
    input  logic [DATA_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_be_n,
    input  logic              req_write,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_take,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              par_byte,
    input  logic              err_clr,
    output logic              par_err_pulse,
    output logic              par_err_sticky,
    input  logic              slave_acc,
    input  logic              oe_n,
    output logic [DATA_W-1:0] ad_o,
    input  logic [DATA_W-1:0] ad_i,
    output logic              ad_oe,
    output logic [LANES-1:0]  par_o,
    input  logic [LANES-1:0]  par_i,
    output logic [LANES-1:0]  par_oe,
    output logic [LANES-1:0]  be_n_o,
    output logic              be_oe
);
    localparam logic [LANES-1:0] ALL_LANES = '1;
    localparam logic [LANES-1:0] TOP_LANE  = {1'b1, {(LANES-1){1'b0}}};

    logic              in_addr, in_data, in_idle;
    logic              in_wdata, in_rdata, drive_phase;
    logic [DATA_W-1:0] addr_q;
    logic [LANES-1:0]  be_q;
    logic              wr_q;
    logic [LANES-1:0]  lanes, out_par, in_par;

    mbm_seq #(.LEN_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .slave_acc (slave_acc),
        .req_len   (req_len),
        .req_ack   (req_ack),
        .in_addr   (in_addr),
        .in_data   (in_data),
        .in_idle   (in_idle)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            be_q   <= '1;
            wr_q   <= 1'b0;
        end else if (req_ack) begin
            addr_q <= req_addr;
            be_q   <= req_be_n;
            wr_q   <= req_write;
        end
    end

    always_comb begin
        in_wdata    = in_data && wr_q;
        in_rdata    = in_data && !wr_q;
        drive_phase = in_addr || in_wdata;
        wr_take     = in_wdata;
        ad_o        = in_addr ? addr_q : (in_wdata ? wr_data : '0);
        ad_oe       = drive_phase && !oe_n;
        lanes       = par_byte ? ALL_LANES : TOP_LANE;
        par_oe      = (drive_phase && par_en && !oe_n) ? lanes : '0;
        par_o       = par_en ? (out_par & lanes) : '0;
        be_oe       = in_addr || in_data;
        be_n_o      = be_oe ? be_q : '1;
    end

    mbm_parity #(.DATA_W(DATA_W)) u_par_out (
        .data      (ad_o),
        .odd       (par_odd),
        .byte_mode (par_byte),
        .par       (out_par)
    );

    mbm_parity #(.DATA_W(DATA_W)) u_par_in (
        .data      (ad_i),
        .odd       (par_odd),
        .byte_mode (par_byte),
        .par       (in_par)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= in_rdata;
            if (in_rdata) rd_data <= ad_i;
        end
    end

    mbm_perr #(.LANES(LANES)) u_perr (
        .clk        (clk),
        .rst_n      (rst_n),
        .chk_en     (in_rdata && par_en),
        .lanes      (lanes),
        .par_seen   (par_i),
        .par_want   (in_par),
        .err_clr    (err_clr),
        .err_pulse  (par_err_pulse),
        .err_sticky (par_err_sticky)
    );

    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        in_idle |-> (!ad_oe && !be_oe && par_oe == '0)); // R3
    AST_OE_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!ad_oe && par_oe == '0)); // R9
    AST_WORD_LOW_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        !par_byte |-> (par_oe[LANES-2:0] == '0)); // R7
    AST_PAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !par_en |-> (par_oe == '0)); // R12
    AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_pulse |-> rd_valid); // R10
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        in_rdata |-> (!ad_oe && par_oe == '0)); // R5
endmodule

// File: tb/sim_mux_bus_master.sv
`timescale 1ns/1ps
module sim_mux_bus_master;
    logic        clk = 0, rst_n = 0;
    logic        req = 0, req_ack, req_write = 0;
    logic [31:0] req_addr = 0, wr_data = 0, rd_data, ad_o, ad_i = 0;
    logic [3:0]  req_be_n = 4'hF, req_len = 0, par_o, par_i = 0, par_oe, be_n_o;
    logic        wr_take, rd_valid, par_en = 0, par_odd = 0, par_byte = 0;
    logic        err_clr = 0, par_err_pulse, par_err_sticky, slave_acc = 0, oe_n = 0;
    logic        ad_oe, be_oe;
    int          n_chk = 0, n_fail = 0;
    bit          exp_sticky = 0;

    always #2 clk = ~clk;

    mux_bus_master u0 (.*);

    task automatic chk(string r, logic [63:0] a, logic [63:0] e);
        n_chk++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", r, a, e);
        end
    endtask

    function automatic logic [3:0] f_par(logic [31:0] d, logic odd, logic byt);
        logic [3:0] p = '0;
        if (byt) begin
            for (int k = 0; k < 4; k++) p[k] = ($countones(d[8*k +: 8]) % 2 == 1) ^ odd;
        end else begin
            p[3] = ($countones(d) % 2 == 1) ^ odd;
        end
        return p;
    endfunction

    function automatic logic [3:0] f_lanes(logic byt);
        return byt ? 4'hF : 4'h8;
    endfunction

    task automatic xfer(logic [31:0] addr, logic [3:0] be, logic wr, logic [3:0] len,
                        logic en, logic odd, logic byt, logic force_off,
                        logic [3:0] corrupt, logic clr0);
        logic [31:0] prev_d = 0;
        logic        prev_err = 0;
        logic [3:0]  ln = f_lanes(byt);
        @(negedge clk);
        par_en = en; par_odd = odd; par_byte = byt; oe_n = force_off;
        req = 1; req_addr = addr; req_be_n = be; req_write = wr; req_len = len;
        #1 chk("R2 ack", req_ack, 1);
        @(negedge clk);
        req = 0;
        #1;
        chk("R2 addr on bus", ad_o, addr);
        chk("R9/R2 ad_oe addr", ad_oe, !force_off);
        chk("R2 be_oe", be_oe, 1);
        chk("R2 be value", be_n_o, be);
        chk("R8/R12/R9 par_oe addr", par_oe, (en && !force_off) ? ln : 4'h0);
        if (en) chk("R6/R7 addr parity", par_o & ln, f_par(addr, odd, byt) & ln);
        for (int b = 0; b <= len; b++) begin
            @(negedge clk);
            if (!wr && b > 0) begin
                #0;
                chk("R5 rd_valid", rd_valid, 1);
                chk("R5 rd_data", rd_data, prev_d);
                chk("R10/R12 err pulse", par_err_pulse, prev_err);
                chk("R11 sticky", par_err_sticky, exp_sticky);
            end
            err_clr = clr0 && (b == 0);
            if (wr) begin
                wr_data = $urandom;
                #1;
                chk("R4 wr_take", wr_take, 1);
                chk("R4 ad_o data", ad_o, wr_data);
                chk("R4/R9 ad_oe data", ad_oe, !force_off);
                chk("R8 par_oe write", par_oe, (en && !force_off) ? ln : 4'h0);
                if (en) chk("R6/R7 write parity", par_o & ln, f_par(wr_data, odd, byt) & ln);
            end else begin
                ad_i = $urandom;
                par_i = f_par(ad_i, odd, byt) ^ corrupt;
                prev_d = ad_i;
                prev_err = en && ((corrupt & ln) != 0);
                if (clr0 && b == 0) exp_sticky = prev_err;
                else if (prev_err) exp_sticky = 1;
                #1;
                chk("R5 ad_oe read", ad_oe, 0);
                chk("R8 par_oe read", par_oe, 0);
                chk("R2 be_oe data", be_oe, 1);
            end
        end
        @(negedge clk);
        err_clr = 0;
        #1;
        if (!wr) begin
            chk("R5 last rd_valid", rd_valid, 1);
            chk("R5 last rd_data", rd_data, prev_d);
            chk("R10/R12 last err", par_err_pulse, prev_err);
            chk("R11 last sticky", par_err_sticky, exp_sticky);
        end
        chk("R3 idle ad_oe", ad_oe, 0);
        chk("R3 idle be_oe", be_oe, 0);
        chk("R3 idle par_oe", par_oe, 0);
        oe_n = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        #1;
        chk("R1 ack", req_ack, 0);
        chk("R1 ad_oe", ad_oe, 0);
        chk("R1 be_oe", be_oe, 0);
        chk("R1 be_n", be_n_o, 4'hF);
        chk("R1 par_oe", par_oe, 0);
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 sticky", par_err_sticky, 0);
        @(negedge clk); rst_n = 1;

        // R3: slave access blocks acceptance
        @(negedge clk);
        slave_acc = 1; req = 1;
        #1 chk("R3 no ack under slave", req_ack, 0);
        @(negedge clk); #1;
        chk("R3 be released slave", be_oe, 0);
        chk("R3 ad released slave", ad_oe, 0);
        req = 0; slave_acc = 0;

        // directed: byte-mode even write, odd word-mode read with error
        xfer(32'h8000_00FF, 4'b0101, 1, 4'd2, 1, 0, 1, 0, 4'h0, 0);
        xfer(32'h1234_5678, 4'b0000, 0, 4'd1, 1, 1, 0, 0, 4'h8, 0);
        // R7: corruption of low lanes ignored in word mode
        xfer(32'h0000_0010, 4'b0000, 0, 4'd0, 1, 0, 0, 0, 4'h7, 0);
        // R11: clear alone in idle
        @(negedge clk); err_clr = 1;
        @(negedge clk); err_clr = 0; exp_sticky = 0;
        #1 chk("R11 cleared", par_err_sticky, 0);
        // R11: error and clear in the same clock, error wins
        xfer(32'h0000_0020, 4'b0000, 0, 4'd1, 1, 0, 1, 0, 4'h2, 1);
        chk("R11 collision keeps set", par_err_sticky, 1);
        // R12: disabled parity ignores corrupt lanes and drives nothing
        @(negedge clk); err_clr = 1;
        @(negedge clk); err_clr = 0; exp_sticky = 0;
        xfer(32'h0000_0030, 4'b1110, 0, 4'd1, 0, 0, 1, 0, 4'hF, 0);
        xfer(32'h0000_0040, 4'b1110, 1, 4'd1, 0, 1, 1, 0, 4'h0, 0);
        // R9: output-enable override during write
        xfer(32'hCAFE_0000, 4'b0011, 1, 4'd2, 1, 1, 1, 1, 4'h0, 0);

        for (int i = 0; i < 40; i++) begin
            logic [3:0] cor = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
            xfer($urandom, 4'($urandom), 1'($urandom), 4'($urandom % 4),
                 1'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom % 8 == 0), cor, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule